// File: doc/BRIEF.md
# Sparse Pixel-Matrix Hit Readout

This block collects discriminator hit pulses from a pixel matrix and reads them out frame by frame. The matrix is split into sub-matrices. Each one has its own readout path and its own output stream, and all of them run in parallel. Time is cut into frames of a programmable number of clock cycles. During a frame every pixel counts its hits into an acquisition bank. At the frame boundary the acquisition bank becomes the readout bank in a single cycle, and a cleared bank takes over acquisition at once. Hits arriving during readout are never lost, so the block has no dead time.

Two modes are available. In sparse mode a priority encoder in each sub-matrix presents only the pixels that were hit, lowest local index first, and each word carries the pixel's saturating hit count. In imaging mode every pixel of the sub-matrix is presented, with its count, including those that stayed at zero. The mode input is sampled only on a frame boundary.

Each sub-matrix streams words over valid/ready. A word, once valid, holds its value until the consumer accepts it. The one exception is a frame boundary that arrives while words are still unread: those words are discarded, and the sub-matrix's overflow flag pulses. Back-pressure on one stream never stalls another. The defaults give a small instance. A full-size array uses 16 sub-matrices of 256 pixels, which produces a 16-bit word.

Top module: `pxr_readout`

## Requirements
- R1: Each pixel counts the clock edges on which its hit input is high within one frame, saturating at 2^CNT_W-1 (15 with defaults).
- R2: A frame boundary falls every frame_len_i cycles. frame_tick_o is high in the cycle whose closing edge is the boundary, and a hit sampled on that edge counts in the new frame.
- R3: In sparse mode (mode_i = 0) a sub-matrix presents exactly the pixels with a nonzero count, in ascending local index order.
- R4: In imaging mode (mode_i = 1) a sub-matrix presents every one of its pixels in ascending local index order, zero counts included.
- R5: Word fields, MSB to LSB: sub-matrix index (SUB_W bits), local pixel index (ADDR_W bits), count (CNT_W bits). Global hit bit p maps to sub-matrix p / SUB_PIX and local index p % SUB_PIX.
- R6: out_last_o is high with the final word of a sub-matrix's frame and low with every other word.
- R7: A frame's first word is valid in the cycle after its boundary edge. A valid word that is not accepted stays valid and unchanged. After an acceptance, the next pending pixel is presented in the following cycle.
- R8: If a sub-matrix still holds unaccepted words at a boundary, its ovf_o bit is high for the one cycle after that edge, and those words are never presented.
- R9: mode_i is sampled only on a boundary edge and sets the mode of the frame that starts there. Changes of mode_i between boundaries have no effect.
- R10: While rst is high and after it is released, no word is valid and no overflow is flagged. The first frame after reset is sparse.
- R11: Sub-matrices are independent: a stalled stream neither delays nor flags the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_len_i | input | FRAME_W | Frame length in cycles |
| mode_i | input | 1 | 0 sparse, 1 imaging; sampled at boundaries |
| hit_i | input | NUM_SUB*SUB_PIX | Per-pixel hit pulses |
| frame_tick_o | output | 1 | High in the cycle ending at a frame boundary |
| out_valid_o | output | NUM_SUB | Word valid, one bit per sub-matrix |
| out_ready_i | input | NUM_SUB | Consumer ready, one bit per sub-matrix |
| out_data_o | output | NUM_SUB*WORD_W | Words; sub-matrix s at bits s*WORD_W +: WORD_W |
| out_last_o | output | NUM_SUB | Final word of the frame for that sub-matrix |
| ovf_o | output | NUM_SUB | Readout overrun pulse per sub-matrix |

## Verification
A word is accepted on the rising edge where valid and ready are both high. The bench therefore samples the streams one nanosecond after each falling edge and compares every accepted word against a per-sub-matrix queue of expected words. The expected words are built from the hit counts the bench itself drove in the previous frame. The first word of a frame is checked one cycle after the boundary edge, the overflow pulse exactly one cycle after the boundary that catches unread words, and tick spacing against frame_len_i cycles. Hits are driven on the falling edge that precedes the boundary edge, so that the bench counts them in the new frame.

// File: rtl/pxr_pkg.sv
package pxr_pkg;
  typedef enum logic {
    PXR_SPARSE = 1'b0,
    PXR_IMAGE  = 1'b1
  } pxr_mode_e;
endpackage

// File: rtl/pxr_frame_timer.sv
module pxr_frame_timer #(
  parameter int FRAME_W = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [FRAME_W-1:0] frame_len_i,
  output logic               swap_o
);
  logic [FRAME_W-1:0] cyc_q;
  logic [FRAME_W:0]   cyc_next;

  // a length of 0 or 1 degenerates to a boundary on every edge
  assign cyc_next = {1'b0, cyc_q} + (FRAME_W+1)'(1);
  assign swap_o   = cyc_next >= {1'b0, frame_len_i};

  always_ff @(posedge clk) begin
    if (rst)         cyc_q <= '0;
    else if (swap_o) cyc_q <= '0;
    else             cyc_q <= cyc_next[FRAME_W-1:0];
  end

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
    (swap_o && frame_len_i > FRAME_W'(1)) |=> (!swap_o || !$stable(frame_len_i))); // R2
endmodule

// File: rtl/pxr_prio_enc.sv
module pxr_prio_enc #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     req_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             single_o
);
  logic [N-1:0] below_lowest;

  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign found_o      = |req_i;
  assign below_lowest = req_i & (req_i - N'(1));
  assign single_o     = found_o && (below_lowest == '0);
endmodule

// File: rtl/pxr_submatrix.sv
module pxr_submatrix
  import pxr_pkg::*;
#(
  parameter int SUB_IDX = 0,
  parameter int SUB_PIX = 16,
  parameter int CNT_W   = 4,
  parameter int SUB_W   = 2,
  parameter int ADDR_W  = 4,
  localparam int WORD_W = SUB_W + ADDR_W + CNT_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               swap_i,
  input  pxr_mode_e          acq_mode_i,
  input  logic [SUB_PIX-1:0] hit_i,
  input  logic               ready_i,
  output logic               valid_o,
  output logic [WORD_W-1:0]  data_o,
  output logic               last_o,
  output logic               ovf_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [SUB_W-1:0] MY_IDX  = SUB_W'(SUB_IDX);

  logic [CNT_W-1:0]   acq_cnt [SUB_PIX];
  logic [CNT_W-1:0]   rd_cnt  [SUB_PIX];
  logic [SUB_PIX-1:0] pend_q;
  logic [SUB_PIX-1:0] clr_mask;
  logic [ADDR_W-1:0]  sel_idx;
  logic               sel_found;
  logic               sel_single;
  logic               accept;
  pxr_mode_e          rd_mode_q;

  pxr_prio_enc #(.N(SUB_PIX), .IDX_W(ADDR_W)) u_enc (
    .req_i   (pend_q),
    .found_o (sel_found),
    .idx_o   (sel_idx),
    .single_o(sel_single)
  );

  assign accept   = sel_found && ready_i;
  assign clr_mask = accept ? (SUB_PIX'(1) << sel_idx) : '0;

  for (genvar p = 0; p < SUB_PIX; p++) begin : g_pix
    // acquisition bank: a hit on the boundary edge opens the new frame
    always_ff @(posedge clk) begin
      if (rst)                              acq_cnt[p] <= '0;
      else if (swap_i)                      acq_cnt[p] <= hit_i[p] ? CNT_W'(1) : '0;
      else if (hit_i[p] && acq_cnt[p] != CNT_MAX) acq_cnt[p] <= acq_cnt[p] + CNT_W'(1);
    end

    // readout bank and its pending flag
    always_ff @(posedge clk) begin
      if (rst) begin
        rd_cnt[p] <= '0;
        pend_q[p] <= 1'b0;
      end else if (swap_i) begin
        rd_cnt[p] <= acq_cnt[p];
        pend_q[p] <= (acq_mode_i == PXR_IMAGE) || (acq_cnt[p] != '0);
      end else if (clr_mask[p]) begin
        pend_q[p] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_o     <= 1'b0;
      rd_mode_q <= PXR_SPARSE;
    end else begin
      ovf_o <= swap_i && ((pend_q & ~clr_mask) != '0);
      if (swap_i) rd_mode_q <= acq_mode_i;
    end
  end

  assign valid_o = sel_found;
  assign data_o  = {MY_IDX, sel_idx, rd_cnt[sel_idx]};
  assign last_o  = sel_single;

  AST_HOLD_WORD: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !ready_i && !swap_i) |=> (valid_o && $stable(data_o))); // R7
  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (rst)
    (valid_o && last_o && ready_i && !swap_i) |=> !valid_o); // R6
  AST_OVF_AT_SWAP: assert property (@(posedge clk) disable iff (rst)
    ovf_o |-> $past(swap_i)); // R8
  AST_SPARSE_NONZERO: assert property (@(posedge clk) disable iff (rst)
    (valid_o && rd_mode_q == PXR_SPARSE) |-> (data_o[CNT_W-1:0] != '0)); // R3
endmodule

// File: rtl/pxr_readout.sv
module pxr_readout
  import pxr_pkg::*;
#(
  parameter int NUM_SUB  = 4,
  parameter int SUB_PIX  = 16,
  parameter int CNT_W    = 4,
  parameter int FRAME_W  = 12,
  localparam int SUB_W   = (NUM_SUB > 1) ? $clog2(NUM_SUB) : 1,
  localparam int ADDR_W  = (SUB_PIX > 1) ? $clog2(SUB_PIX) : 1,
  localparam int WORD_W  = SUB_W + ADDR_W + CNT_W,
  localparam int NUM_PIX = NUM_SUB * SUB_PIX
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [FRAME_W-1:0]        frame_len_i,
  input  logic                      mode_i,
  input  logic [NUM_PIX-1:0]        hit_i,
  output logic                      frame_tick_o,
  output logic [NUM_SUB-1:0]        out_valid_o,
  input  logic [NUM_SUB-1:0]        out_ready_i,
  output logic [NUM_SUB*WORD_W-1:0] out_data_o,
  output logic [NUM_SUB-1:0]        out_last_o,
  output logic [NUM_SUB-1:0]        ovf_o
);
  logic      swap;
  pxr_mode_e acq_mode_q;

  pxr_frame_timer #(.FRAME_W(FRAME_W)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .frame_len_i(frame_len_i),
    .swap_o     (swap)
  );

  assign frame_tick_o = swap;

  // mode of the frame being acquired; latched only on a boundary edge
  always_ff @(posedge clk) begin
    if (rst)       acq_mode_q <= PXR_SPARSE;
    else if (swap) acq_mode_q <= pxr_mode_e'(mode_i);
  end

  AST_MODE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    !swap |=> $stable(acq_mode_q)); // R9

  for (genvar s = 0; s < NUM_SUB; s++) begin : g_sub
    pxr_submatrix #(
      .SUB_IDX(s),
      .SUB_PIX(SUB_PIX),
      .CNT_W  (CNT_W),
      .SUB_W  (SUB_W),
      .ADDR_W (ADDR_W)
    ) u_sub (
      .clk       (clk),
      .rst       (rst),
      .swap_i    (swap),
      .acq_mode_i(acq_mode_q),
      .hit_i     (hit_i[s*SUB_PIX +: SUB_PIX]),
      .ready_i   (out_ready_i[s]),
      .valid_o   (out_valid_o[s]),
      .data_o    (out_data_o[s*WORD_W +: WORD_W]),
      .last_o    (out_last_o[s]),
      .ovf_o     (ovf_o[s])
    );
  end
endmodule

// File: tb/test_pxr_readout.sv
module test_pxr_readout;
  localparam int NS  = 4;
  localparam int SP  = 16;
  localparam int NP  = NS * SP;
  localparam int CW  = 4;
  localparam int FW  = 12;
  localparam int WW  = 2 + 4 + CW;
  localparam int LEN = 40;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [FW-1:0]   frame_len_i = FW'(LEN);
  logic            mode_i = 1'b0;
  logic [NP-1:0]   hit_i = '0;
  logic            frame_tick_o;
  logic [NS-1:0]   out_valid_o;
  logic [NS-1:0]   out_ready_i = '1;
  logic [NS*WW-1:0] out_data_o;
  logic [NS-1:0]   out_last_o;
  logic [NS-1:0]   ovf_o;

  pxr_readout #(.NUM_SUB(NS), .SUB_PIX(SP), .CNT_W(CW), .FRAME_W(FW)) i_pxr_readout (
    .clk(clk), .rst(rst), .frame_len_i(frame_len_i), .mode_i(mode_i), .hit_i(hit_i),
    .frame_tick_o(frame_tick_o), .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
    .out_data_o(out_data_o), .out_last_o(out_last_o), .ovf_o(ovf_o)
  );

  always #2 clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;
  logic [WW:0] exp_q [NS][$];
  int  pat [NP];
  bit  prev_ne [NS];
  bit  bp_en = 1'b0;
  int  bp_cyc = 0;
  bit  tick_seen = 1'b0;
  int  tick_gap = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: compare every accepted word with the scoreboard
  always begin
    @(negedge clk); #1;
    if (!rst) begin
      for (int s = 0; s < NS; s++) begin
        if (out_valid_o[s] && out_ready_i[s]) begin
          logic [WW:0] got;
          got = {out_last_o[s], out_data_o[s*WW +: WW]};
          if (exp_q[s].size() == 0) chk(1'b0, "R3/R4 unexpected word", int'(got), 0);
          else begin
            logic [WW:0] want;
            want = exp_q[s].pop_front();
            chk(got == want, "R1/R5/R6 word {last,sub,idx,cnt}", int'(got), int'(want));
          end
        end
      end
    end
  end

  // R2: boundary spacing
  always @(negedge clk) begin
    if (!rst) begin
      if (frame_tick_o) begin
        if (tick_seen) chk(tick_gap == LEN, "R2 tick spacing", tick_gap, LEN);
        tick_seen = 1'b1;
        tick_gap = 1;
      end else tick_gap++;
    end
  end

  // R7/R11: back-pressure on sub-matrix 2
  always @(negedge clk) begin
    if (bp_en) begin
      bp_cyc++;
      out_ready_i[2] = (bp_cyc % 3) != 0;
    end
  end

  initial begin
    #(4 * 200000);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  task automatic clear_pat();
    for (int p = 0; p < NP; p++) pat[p] = 0;
  endtask

  // drive one whole frame from pat[], then queue the words it must yield
  task automatic run_frame(input bit m, input bit glitch);
    @(negedge clk);
    while (frame_tick_o !== 1'b1) @(negedge clk);
    for (int c = 0; c < LEN; c++) begin
      if (c > 0) @(negedge clk);
      mode_i = (glitch && c >= 5 && c < 11) ? ~m : m;
      for (int p = 0; p < NP; p++) hit_i[p] = (c < pat[p]);
      if (c == 1)
        for (int s = 0; s < NS; s++)
          chk(out_valid_o[s] == prev_ne[s], "R7 first word one cycle after boundary",
              int'(out_valid_o[s]), int'(prev_ne[s]));
    end
    for (int s = 0; s < NS; s++) begin
      logic [WW-1:0] words[$];
      for (int l = 0; l < SP; l++) begin
        int n;
        n = pat[s*SP + l];
        if (n > 15) n = 15;
        if (m || n != 0) words.push_back({2'(s), 4'(l), 4'(n)});
      end
      for (int k = 0; k < words.size(); k++)
        exp_q[s].push_back({k == words.size() - 1, words[k]});
      prev_ne[s] = words.size() != 0;
    end
  endtask

  initial begin
    for (int s = 0; s < NS; s++) prev_ne[s] = 1'b0;
    repeat (4) @(negedge clk);
    chk(out_valid_o == '0, "R10 no valid in reset", int'(out_valid_o), 0);
    chk(ovf_o == '0, "R10 no overflow in reset", int'(ovf_o), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid_o == '0, "R10 no valid after reset", int'(out_valid_o), 0);

    // A: sparse; saturation (R1), boundary-edge hit (R2), ordering (R3)
    clear_pat();
    pat[3] = 2; pat[0] = 1; pat[15] = 20;
    pat[2*SP + 7] = 5;
    pat[3*SP + 1] = 1; pat[3*SP + 2] = 15;
    run_frame(1'b0, 1'b0);

    // B: imaging, all pixels including zeros (R4)
    clear_pat();
    pat[2] = 4; pat[SP + 15] = 16;
    run_frame(1'b1, 1'b0);

    // C: sparse with mode toggled mid-frame (R9)
    clear_pat();
    pat[SP + 5] = 3; pat[3*SP + 9] = 1;
    run_frame(1'b0, 1'b1);

    // D: many hits on sub 2, read out under back-pressure in E (R7, R11)
    clear_pat();
    for (int l = 0; l < 6; l++) pat[2*SP + 2*l + 1] = l + 1;
    pat[3*SP + 14] = 7;
    run_frame(1'b0, 1'b0);
    bp_en = 1'b1;
    clear_pat();
    run_frame(1'b0, 1'b0);
    bp_en = 1'b0;
    out_ready_i[2] = 1'b1;

    // F/G: sub 0 stalls across a boundary (R8), sub 1 unaffected (R11)
    out_ready_i[0] = 1'b0;
    clear_pat();
    pat[4] = 3; pat[9] = 1; pat[SP + 0] = 2;
    run_frame(1'b0, 1'b0);
    clear_pat();
    run_frame(1'b0, 1'b0);
    @(negedge clk);
    chk(frame_tick_o == 1'b1, "R2 boundary due", int'(frame_tick_o), 1);
    @(negedge clk);
    chk(ovf_o == 4'b0001, "R8 R11 overflow only on stalled sub", int'(ovf_o), 1);
    chk(out_valid_o[0] == 1'b0, "R8 unread words dropped", int'(out_valid_o[0]), 0);
    exp_q[0].delete();
    @(negedge clk);
    chk(ovf_o == '0, "R8 overflow is one cycle", int'(ovf_o), 0);
    out_ready_i[0] = 1'b1;
    for (int s = 0; s < NS; s++) prev_ne[s] = 1'b0;

    // H: drain
    clear_pat();
    run_frame(1'b0, 1'b0);
    repeat (LEN) @(negedge clk);
    for (int s = 0; s < NS; s++)
      chk(exp_q[s].size() == 0, "R3/R4 all expected words delivered", exp_q[s].size(), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule